// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Doorbells

This block is a clocked RAM with two independent ports, left and right. Each port has its own enable, write strobe, output enable, address and data. Both ports reach one shared word array, and they may touch the same word in the same cycle. Reads are synchronous. The addressed word is captured into a per-port output register on the clock edge that samples the read.

The two uppermost words of the array also serve as doorbells between the ports:

- The very top word belongs to the right port.
- The word just below it belongs to the left port.

When the opposite port writes a doorbell word, the owner's active-low interrupt output drops. The interrupt rises again when the owner reads that word. Software on one side can therefore leave a message in the other side's mailbox and signal it in the same access. The mailbox words otherwise behave as ordinary storage.

Top module: `dpd_top`

## Requirements
- R1: While reset is high and after it, until the next relevant access, both interrupt outputs are high and both read-data outputs are zero.
- R2: A port read (enable 1, write 0) presents the addressed word on that port's read-data output after the next clock edge. A word written through either port can be read back through either port.
- R3: A read on one port and a write on the other port to the same address in the same cycle returns the word's contents from before that write.
- R4: If both ports write the same address in one cycle, the left port's data is stored.
- R5: An enabled left write to the top address (all address bits 1) drives the right interrupt output low at the next clock edge.
- R6: An enabled right write to the top address minus one drives the left interrupt output low at the next clock edge.
- R7: An enabled read by the owner of its own mailbox returns its interrupt output high at the next clock edge.
- R8: If a doorbell is set and cleared in the same cycle, the set wins and the interrupt output stays low.
- R9: These accesses leave an interrupt output unchanged: an owner writing its own mailbox, and any mailbox access with the port enable low.
- R10: Mailbox words store and return data like any other word.
- R11: With output enable low, a port's read-data output is zero. The read-data register changes only in cycles in which that port reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_int_n | output | 1 | Left doorbell interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_int_n | output | 1 | Right doorbell interrupt, active low |

## Verification
A wrong doorbell flag shows on an interrupt pin at the clock edge right after the access that should have moved it. A flag that sticks, misses or toggles on a disallowed access is therefore caught in one cycle. Corrupted storage or a wrong collision winner stays hidden until the word is read back; it then appears on the read data one edge after that read. The bench therefore sweeps every address through both ports and reads each mailbox soon after each doorbell event.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  // Port identity; index 0 is left, 1 is right.
  typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;

  // Distance of a side's mailbox below the top word.
  function automatic int unsigned mbox_offset(side_e s);
    return (s == SIDE_RIGHT) ? 0 : 1;
  endfunction
endpackage

// File: rtl/dpd_store.sv
module dpd_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_q,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right first, left second: on a shared address the left write lands last.
  always_ff @(posedge clk) begin
    if (r_en && r_we) mem[r_addr] <= r_wdata;
    if (l_en && l_we) mem[l_addr] <= l_wdata;
  end

  // Read-first registers: they sample the array before this edge's writes.
  always_ff @(posedge clk) begin
    if (rst)               l_q <= '0;
    else if (l_en && !l_we) l_q <= mem[l_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)               r_q <= '0;
    else if (r_en && !r_we) r_q <= mem[r_addr];
  end

  // R11
  l_rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_en && !l_we) |=> $stable(l_q));
  // R11
  r_rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(r_en && !r_we) |=> $stable(r_q));
endmodule

// File: rtl/dpd_doorbell.sv
module dpd_doorbell #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] MBOX = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snd_en,
  input  logic              snd_we,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic              own_en,
  input  logic              own_we,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              int_n
);
  logic set_ev, clr_ev;

  assign set_ev = snd_en && snd_we && (snd_addr == MBOX);
  assign clr_ev = own_en && !own_we && (own_addr == MBOX);

  // A set takes priority so that a freshly posted message is never lost.
  always_ff @(posedge clk) begin
    if (rst)         int_n <= 1'b1;
    else if (set_ev) int_n <= 1'b0;
    else if (clr_ev) int_n <= 1'b1;
  end

  // R5
  ring_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> !int_n);
  // R7
  ring_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ev && !set_ev) |=> int_n);
  // R9
  ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_ev && !clr_ev) |=> $stable(int_n));
endmodule

// File: rtl/dpd_top.sv
module dpd_top #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_int_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_int_n
);
  import dpd_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] l_q, r_q;
  logic              en_a  [2];
  logic              we_a  [2];
  logic [ADDR_W-1:0] adr_a [2];
  logic              irq_a [2];

  dpd_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_q(l_q),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_q(r_q)
  );

  assign l_rdata = l_oe ? l_q : '0;
  assign r_rdata = r_oe ? r_q : '0;

  assign en_a[0]  = l_en;
  assign we_a[0]  = l_we;
  assign adr_a[0] = l_addr;
  assign en_a[1]  = r_en;
  assign we_a[1]  = r_we;
  assign adr_a[1] = r_addr;

  // One doorbell per side: the owner is index s, the sender is the other side.
  for (genvar s = 0; s < 2; s++) begin : g_bell
    localparam side_e OWNER = side_e'(s);
    localparam logic [ADDR_W-1:0] BOX = ADDR_W'(DEPTH - 1 - int'(mbox_offset(OWNER)));
    dpd_doorbell #(.ADDR_W(ADDR_W), .MBOX(BOX)) u_bell (
      .clk(clk), .rst(rst),
      .snd_en(en_a[1-s]), .snd_we(we_a[1-s]), .snd_addr(adr_a[1-s]),
      .own_en(en_a[s]),   .own_we(we_a[s]),   .own_addr(adr_a[s]),
      .int_n(irq_a[s])
    );
  end

  assign l_int_n = irq_a[0];
  assign r_int_n = irq_a[1];
endmodule

// File: tb/sim_dpd_top.sv
`timescale 1ns/1ps
module sim_dpd_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam logic [AW-1:0] RBOX = AW'(N - 1);
  localparam logic [AW-1:0] LBOX = AW'(N - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_en = 0, l_we = 0, l_oe = 1, r_en = 0, r_we = 0, r_oe = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_int_n, r_int_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dpd_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_int_n(r_int_n)
  );

  function automatic logic [DW-1:0] pat_l(int a);
    return DW'(a * 37 + 5);
  endfunction
  function automatic logic [DW-1:0] pat_r(int a);
    return DW'(a * 91 + 200);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply one cycle of port activity, then wait to the following negedge.
  task automatic step(logic le, logic lw, logic [AW-1:0] la, logic [DW-1:0] ld,
                      logic re, logic rw, logic [AW-1:0] ra, logic [DW-1:0] rd);
    l_en = le; l_we = lw; l_addr = la; l_wdata = ld;
    r_en = re; r_we = rw; r_addr = ra; r_wdata = rd;
    @(negedge clk);
    l_en = 0; r_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 l_int_n", l_int_n, 1); chk("R1 r_int_n", r_int_n, 1);
    chk("R1 l_rdata", l_rdata, 0); chk("R1 r_rdata", r_rdata, 0);
    rst = 0;
    @(negedge clk);

    // R2/R10 sweep: left writes everything, right reads back
    for (int a = 0; a < N; a++) step(1, 1, AW'(a), pat_l(a), 0, 0, '0, '0);
    chk("R5 sweep sets r_int_n", r_int_n, 0);
    for (int a = 0; a < N; a++) begin
      step(0, 0, '0, '0, 1, 0, AW'(a), '0);
      chk("R2 right read", r_rdata, pat_l(a));
    end
    chk("R7 sweep clears r_int_n", r_int_n, 1);
    // Right writes everything, left reads back
    for (int a = 0; a < N; a++) step(0, 0, '0, '0, 1, 1, AW'(a), pat_r(a));
    chk("R6 sweep sets l_int_n", l_int_n, 0);
    for (int a = 0; a < N; a++) begin
      step(1, 0, AW'(a), '0, 0, 0, '0, '0);
      chk("R10 left read", l_rdata, pat_r(a));
    end
    chk("R7 sweep clears l_int_n", l_int_n, 1);
    chk("R1 r_int_n idle", r_int_n, 1);

    // R5 left rings right
    step(1, 1, RBOX, 8'hA1, 0, 0, '0, '0);
    chk("R5 r_int_n", r_int_n, 0); chk("R5 l_int_n", l_int_n, 1);
    // R9 owner write to own box
    step(0, 0, '0, '0, 1, 1, RBOX, 8'h5C);
    chk("R9 own write", r_int_n, 0);
    // R9 read without enable; R11 register unchanged
    step(0, 0, '0, '0, 0, 0, RBOX, '0);
    chk("R9 disabled read", r_int_n, 0);
    chk("R11 rdata hold", r_rdata, pat_l(N - 1));
    // R7 clear, R10 data from owner's write
    step(0, 0, '0, '0, 1, 0, RBOX, '0);
    chk("R7 r_int_n", r_int_n, 1); chk("R10 mbox data", r_rdata, 8'h5C);
    // R8 set and clear together; R3 read-first
    step(1, 1, RBOX, 8'h77, 1, 0, RBOX, '0);
    chk("R8 r_int_n", r_int_n, 0); chk("R3 old data", r_rdata, 8'h5C);
    step(0, 0, '0, '0, 1, 0, RBOX, '0);
    chk("R7 r_int_n again", r_int_n, 1); chk("R10 new data", r_rdata, 8'h77);

    // R6 right rings left
    step(0, 0, '0, '0, 1, 1, LBOX, 8'h3E);
    chk("R6 l_int_n", l_int_n, 0); chk("R6 r_int_n", r_int_n, 1);
    step(1, 1, LBOX, 8'h4F, 0, 0, '0, '0);
    chk("R9 left own write", l_int_n, 0);
    step(1, 0, LBOX, '0, 0, 0, '0, '0);
    chk("R7 l_int_n", l_int_n, 1); chk("R10 left mbox", l_rdata, 8'h4F);
    // R9 disabled sender write
    step(0, 0, '0, '0, 0, 1, LBOX, 8'h11);
    chk("R9 disabled write", l_int_n, 1);

    // R4 collision write
    step(1, 1, AW'(3), 8'hC3, 1, 1, AW'(3), 8'h3C);
    step(0, 0, '0, '0, 1, 0, AW'(3), '0);
    chk("R4 left wins", r_rdata, 8'hC3);
    // R3 left write while right reads
    step(1, 1, AW'(5), 8'hD5, 1, 0, AW'(5), '0);
    chk("R3 read-first", r_rdata, pat_r(5));
    step(1, 0, AW'(5), '0, 0, 0, '0, '0);
    chk("R3 then new", l_rdata, 8'hD5);
    // R11 output enable gating
    l_oe = 0; #1;
    chk("R11 oe low", l_rdata, 0);
    l_oe = 1; #1;
    chk("R11 oe high", l_rdata, 8'hD5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule